// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block forms the full double-width product of two 32-bit operands over many clock cycles with one adder that is only as wide as a single operand. A pulse on `start` while the unit is idle captures both operands and a mode select. The unit then spends one cycle per multiplier bit. In each of those cycles it conditionally adds the multiplicand into the upper half of a double-width product register and shifts the whole register right by one place. The multiplier begins in the lower half of that register and is consumed from the bottom as the product bits move in from the top.

In signed mode the unit multiplies the magnitudes of the two operands. It then negates the 64-bit result when exactly one operand is negative. The finished product appears as two 32-bit words, an upper word and a lower word. Both words hold their value until the next operation finishes. `busy` covers the whole operation. `done` marks completion with a single-cycle pulse.

Top module: `seq_shift_mult`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it falls, `busy` and `done` are 0 and both product words are 0.
- R2: A `start` seen high at a clock edge while `busy` is 0 is accepted. `busy` is 1 from that edge until the 33rd edge after it.
- R3: `done` is 1 in exactly one cycle per accepted start: the cycle after the 33rd edge following the accepting edge. `busy` is 0 in that cycle.
- R4: With `signed_mode` = 0, {`prod_hi`,`prod_lo`} equals the unsigned 64-bit product of `op_a` and `op_b` in the `done` cycle.
- R5: With `signed_mode` = 1, {`prod_hi`,`prod_lo`} equals the two's-complement 64-bit product of `op_a` and `op_b`, both read as signed values.
- R6: `op_a`, `op_b` and `signed_mode` are sampled only at the accepting edge. Changing them while `busy` is 1 does not alter the result.
- R7: A `start` pulse while `busy` is 1 is ignored. It does not restart the count, and the result and `done` timing stay those of the running operation.
- R8: Both product words keep their value in every cycle in which `done` is 0.
- R9: No carry is lost. 0xFFFFFFFF × 0xFFFFFFFF unsigned gives 0xFFFFFFFE00000001, and 0x80000000 × 0x80000000 signed gives 0x4000000000000000.
- R10: A signed product of zero gives 0 even when the operand signs differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| signed_mode | input | 1 | 1: operands are two's complement; 0: unsigned |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prod_hi | output | 32 | Upper word of the product |
| prod_lo | output | 32 | Lower word of the product |

## Verification
The accepting edge is followed by 32 step edges and one sign-correction edge. `busy` therefore reads 1 after the accepting edge and through the 33rd edge, and `done` together with the new product is due just after the 33rd edge. The bench drives inputs on falling edges and samples on falling edges. It checks `busy` at the first and the 33rd falling edge after acceptance, `done` and both product words at the 34th, and the cleared `done` with unchanged words at the 35th. The interruption test changes the operands and pulses `start` partway through a run. It then checks the same falling edges against the first operation's product.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

    parameter int unsigned DEF_OPW = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } mstate_e;

    // control strobes issued by the sequencer to the datapath
    typedef struct packed {
        logic load;
        logic step;
        logic finish;
    } mctl_t;

endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep #(
    parameter int unsigned W = mulseq_pkg::DEF_OPW
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         signed_mode,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_result
);
    logic a_neg;
    logic b_neg;

    always_comb begin
        a_neg      = signed_mode & a_in[W-1];
        b_neg      = signed_mode & b_in[W-1];
        mag_a      = a_neg ? (~a_in + 1'b1) : a_in;
        mag_b      = b_neg ? (~b_in + 1'b1) : b_in;
        neg_result = a_neg ^ b_neg;
    end

    // R5: a magnitude with its top bit set only comes from the most negative value
    always_comb begin
        if (signed_mode && mag_a[W-1])
            assert_mag_a_range_R5: assert (a_in == {1'b1, {(W-1){1'b0}}});
    end

endmodule

// File: rtl/mul_step_dp.sv
module mul_step_dp #(
    parameter int unsigned W = mulseq_pkg::DEF_OPW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] prod
);
    localparam int unsigned PW = 2 * W;

    logic [W-1:0]  mcand_q;
    logic [PW-1:0] prod_q;
    logic [W:0]    upper_sum;

    // single operand-wide adder; carry-out kept as bit W
    always_comb begin
        if (prod_q[0])
            upper_sum = {1'b0, prod_q[PW-1:W]} + {1'b0, mcand_q};
        else
            upper_sum = {1'b0, prod_q[PW-1:W]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            prod_q  <= {{W{1'b0}}, mplier_in};
        end else if (step) begin
            prod_q  <= {upper_sum, prod_q[W-1:1]};
        end
    end

    assign prod = prod_q;

    // R4: a step with nothing added cannot set the top bit
    assert_noadd_top_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !prod_q[0]) |=> (prod_q[PW-1] == 1'b0));

endmodule

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl
    import mulseq_pkg::*;
#(
    parameter int unsigned W = DEF_OPW
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output mctl_t ctl,
    output logic  busy,
    output logic  done
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mstate_e       state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_comb begin
        ctl.load   = (state_q == ST_IDLE) && start;
        ctl.step   = (state_q == ST_RUN);
        ctl.finish = (state_q == ST_FIX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= ctl.finish;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_RUN;
                    cnt_q   <= '0;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST)
                        state_q <= ST_FIX;
                end
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

    assert_start_accepted_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7: a start during a run never disturbs the step count
    assert_run_count_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && cnt_q != LAST) |=>
        (state_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/seq_shift_mult.sv
module seq_shift_mult
    import mulseq_pkg::*;
#(
    parameter int unsigned W = DEF_OPW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo
);
    localparam int unsigned PW = 2 * W;

    mctl_t         ctl;
    logic [W-1:0]  mag_a;
    logic [W-1:0]  mag_b;
    logic          neg_now;
    logic          neg_q;
    logic [PW-1:0] raw_prod;
    logic [PW-1:0] result_q;

    mul_operand_prep #(.W(W)) u_prep (
        .a_in        (op_a),
        .b_in        (op_b),
        .signed_mode (signed_mode),
        .mag_a       (mag_a),
        .mag_b       (mag_b),
        .neg_result  (neg_now)
    );

    mul_seq_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    mul_step_dp #(.W(W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.load),
        .step      (ctl.step),
        .mcand_in  (mag_a),
        .mplier_in (mag_b),
        .prod      (raw_prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            neg_q    <= 1'b0;
            result_q <= '0;
        end else begin
            if (ctl.load)
                neg_q <= neg_now;
            if (ctl.finish)
                result_q <= neg_q ? (~raw_prod + 1'b1) : raw_prod;
        end
    end

    assign prod_hi = result_q[PW-1:W];
    assign prod_lo = result_q[W-1:0];

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({prod_hi, prod_lo}));

endmodule

// File: tb/seq_shift_mult_test.sv
`timescale 1ns/1ps
module seq_shift_mult_test;

    typedef struct packed {
        logic        sm;
        logic [31:0] a;
        logic [31:0] b;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'd6,          32'd5},
        '{1'b0, 32'd0,          32'hDEAD_BEEF},
        '{1'b0, 32'hFFFF_FFFF,  32'hFFFF_FFFF},
        '{1'b0, 32'h8000_0000,  32'd2},
        '{1'b0, 32'h1234_5678,  32'h9ABC_DEF0},
        '{1'b1, 32'hFFFF_FFFF,  32'd1},
        '{1'b1, 32'h8000_0000,  32'h8000_0000},
        '{1'b1, 32'h7FFF_FFFF,  32'h8000_0000},
        '{1'b1, 32'd0,          32'hFFFF_FFFB},
        '{1'b1, 32'hFFFF_FFFA,  32'hFFFF_FFF9},
        '{1'b1, 32'd12345,      32'hFFFF_FF00},
        '{1'b1, 32'h7FFF_FFFF,  32'h7FFF_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        busy;
    logic        done;
    logic [31:0] prod_hi;
    logic [31:0] prod_lo;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    seq_shift_mult uut (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
        .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fails);
            $finish;
        end
    end

    function automatic logic [63:0] ref_mul(input logic sm, input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] sa;
        logic signed [63:0] sb;
        if (sm) begin
            sa = $signed(a);
            sb = $signed(b);
            return 64'(sa * sb);
        end
        return {32'd0, a} * {32'd0, b};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fails = n_fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // full operation with timing checks; called at a falling edge
    task automatic run_op(input logic sm, input logic [31:0] a, input logic [31:0] b, input string req);
        logic [63:0] exp;
        exp = ref_mul(sm, a, b);
        signed_mode = sm; op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
        repeat (32) @(negedge clk);
        chk(busy == 1'b1 && done == 1'b0, "R2 busy through last step", {62'd0, busy, done}, 64'd2);
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R3 done pulse", {62'd0, busy, done}, 64'd1);
        chk({prod_hi, prod_lo} == exp, req, {prod_hi, prod_lo}, exp);
        @(negedge clk);
        chk(done == 1'b0, "R3 done one cycle", 64'(done), 64'd0);
        chk({prod_hi, prod_lo} == exp, "R8 result held", {prod_hi, prod_lo}, exp);
    endtask

    initial begin
        logic [63:0] exp_a;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 flags in reset", {62'd0, busy, done}, 64'd0);
        chk({prod_hi, prod_lo} == 64'd0, "R1 product in reset", {prod_hi, prod_lo}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && {prod_hi, prod_lo} == 64'd0,
            "R1 state after reset", {prod_hi, prod_lo}, 64'd0);

        // table of vectors: R4 unsigned, R5 signed, R9 and R10 corners included
        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].sm, VECS[i].a, VECS[i].b, VECS[i].sm ? "R5 signed product" : "R4 unsigned product");
        end

        // R9: carry retention corners, named explicitly
        run_op(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 unsigned max squared");
        chk({prod_hi, prod_lo} == 64'hFFFF_FFFE_0000_0001, "R9 literal",
            {prod_hi, prod_lo}, 64'hFFFF_FFFE_0000_0001);
        run_op(1'b1, 32'h8000_0000, 32'h8000_0000, "R9 signed min squared");
        chk({prod_hi, prod_lo} == 64'h4000_0000_0000_0000, "R9 signed literal",
            {prod_hi, prod_lo}, 64'h4000_0000_0000_0000);

        // R10: zero with mixed signs
        run_op(1'b1, 32'hFFFF_FFFF, 32'd0, "R10 zero signed");
        chk({prod_hi, prod_lo} == 64'd0, "R10 literal", {prod_hi, prod_lo}, 64'd0);

        // random products in both modes
        for (int i = 0; i < 24; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = $urandom;
            rb = $urandom;
            run_op(i[0], ra, rb, i[0] ? "R5 random signed" : "R4 random unsigned");
        end

        // R6 and R7: change operands and pulse start mid-run
        exp_a = ref_mul(1'b1, 32'hFFFF_FFF0, 32'd7);
        signed_mode = 1'b1; op_a = 32'hFFFF_FFF0; op_b = 32'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_a = 32'd3; op_b = 32'd3; signed_mode = 1'b0;
        repeat (8) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R7 start while busy ignored", {62'd0, busy, done}, 64'd2);
        repeat (23) @(negedge clk);
        chk(busy == 1'b1 && done == 1'b0, "R7 no early finish", {62'd0, busy, done}, 64'd2);
        @(negedge clk);
        chk(done == 1'b1, "R7 done on original schedule", 64'(done), 64'd1);
        chk({prod_hi, prod_lo} == exp_a, "R6 operands latched at accept", {prod_hi, prod_lo}, exp_a);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R7 no second operation", {62'd0, busy, done}, 64'd0);
        repeat (40) @(negedge clk);
        chk(done == 1'b0 && {prod_hi, prod_lo} == exp_a, "R8 result held while idle",
            {prod_hi, prod_lo}, exp_a);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule